// File: doc/BRIEF.md
# Dual-Organisation UV/OTP EPROM Emulator

This block is a synthesizable stand-in for a 16-bit-wide ultraviolet-erasable or one-time-programmable read-only memory. The array can be read a whole word at a time or one byte at a time. A small register array holds the contents, and the control pins are decoded into the device's operating modes. Those modes are word read, byte read, output disable, standby, program, verify, program inhibit and identifier readout. Analog levels are reduced to flags: one says the programming supply is high, and one says address bit 9 carries the high identifier voltage.

Pin 15 of the data bus is shared. When the organisation select is high, pin 15 is data bit 15. When the organisation select is low, pin 15 is sampled as the sub-word address bit that picks the upper or lower byte. Data arrives on `dq_in`. The block drives `dq_out` together with a per-lane enable `dq_oe`, so a surrounding pad ring or testbench can model a bidirectional bus. Programming can only clear bits. The only ways to set bits back to one are the erase input and reset.

All outputs are combinational on the pins and the stored array. Writes, erase and reset take effect at the rising clock edge.

Top module: `eprom_emu`

## Requirements
- R1: After a cycle with `rst_n` low, or a cycle with `erase` high, every word reads 0xFFFF. Erase wins over a program write in the same cycle.
- R2: Word read. Conditions: `ce_n`=0, `oe_n`=0, `byte_n`=1, and no identifier selection. Result: `dq_out` equals the word at `addr` and `dq_oe`=0xFFFF. This also holds when `vpp_hi`=1.
- R3: Byte read. Conditions: `ce_n`=0, `oe_n`=0, `byte_n`=0. Result: `dq_in[15]` is taken as the byte address. 0 puts bits 7:0 of the word on lanes 7:0, and 1 puts bits 15:8 there. `dq_oe`=0x00FF.
- R4: Output disable. With `vpp_hi`=0, `ce_n`=0 and `oe_n`=1, `dq_oe`=0.
- R5: Standby. With `vpp_hi`=0 and `ce_n`=1, `dq_oe`=0 whatever `oe_n` is.
- R6: Program. Conditions: `vpp_hi`=1, `oe_n`=1, `ce_n`=0. Result: `dq_oe`=0. On the first clock of each low pulse of `ce_n`, the word at `addr` becomes old AND `dq_in`. Later cycles of the same pulse write nothing.
- R7: Verify. With `vpp_hi`=1, `ce_n`=1 and `oe_n`=0, the stored word is driven as in R2 or R3.
- R8: Program inhibit. With `vpp_hi`=1, `ce_n`=1 and `oe_n`=1, `dq_oe`=0 and no word changes.
- R9: Identifier. Conditions: `vpp_hi`=0, `a9_hv`=1, `addr` bits above bit 0 all zero, and the read condition of R2/R3. Result: `addr[0]`=0 gives 0x0020 and `addr[0]`=1 gives 0x00B2. Lanes follow the organisation: 16 lanes in word mode, lanes 7:0 in byte mode.
- R10: With `a9_hv`=1 but any address bit above bit 0 set, the array word is read as in R2.
- R11: Any lane with `dq_oe` low reads 0 on `dq_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; fills the array with ones |
| erase | input | 1 | Fills the array with ones at the next edge |
| addr | input | AW | Word address |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| byte_n | input | 1 | Organisation select: 1 word-wide, 0 byte-wide |
| vpp_hi | input | 1 | Programming supply at high voltage |
| a9_hv | input | 1 | Identifier voltage present on address bit 9 |
| dq_in | input | 16 | Data bus as seen from outside; bit 15 is the byte address in byte mode |
| dq_out | output | 16 | Data driven by the block |
| dq_oe | output | 16 | Per-lane drive enable |

## Verification
A corrupted array cell shows up at the ports on the next read or verify of that address, and not before, because nothing else exposes the stored words. A wrong pulse-edge register shows up one cycle after a second write lands inside one chip-enable pulse. It then appears as extra zero bits on the following verify. A mode-decode fault appears in the same cycle as a wrong `dq_oe` pattern. Because of this, the reference model is compared against both output vectors on every clock cycle.

// File: rtl/eprom_emu_pkg.sv
// Shared types and constants for the EPROM emulator.
// Assumes a 16-bit stored word whose top data pin doubles as byte address.
package eprom_emu_pkg;
    localparam int WORD_W = 16;
    localparam int HALF_W = WORD_W / 2;
    localparam logic [HALF_W-1:0] MFR_CODE = 8'h20;
    localparam logic [HALF_W-1:0] DEV_CODE = 8'hB2;

    typedef enum logic [2:0] {
        MD_STANDBY,
        MD_DISABLE,
        MD_READ,
        MD_IDENT,
        MD_PROGRAM,
        MD_VERIFY,
        MD_INHIBIT
    } mode_t;
endpackage

// File: rtl/eprom_mode_dec.sv
// Decodes the control pins into one operating mode.
// Assumes the identifier address check is done by the caller (id_sel).
module eprom_mode_dec
    import eprom_emu_pkg::*;
(
    input  logic  ce_n,
    input  logic  oe_n,
    input  logic  vpp_hi,
    input  logic  id_sel,
    output mode_t mode
);
    // Mode table: the high-voltage supply selects the programming group
    always_comb begin
        if (vpp_hi) begin
            if (!ce_n && oe_n)       mode = MD_PROGRAM;
            else if (ce_n && oe_n)   mode = MD_INHIBIT;
            else if (ce_n && !oe_n)  mode = MD_VERIFY;
            else                     mode = MD_READ;
        end else begin
            if (ce_n)                mode = MD_STANDBY;
            else if (oe_n)           mode = MD_DISABLE;
            else if (id_sel)         mode = MD_IDENT;
            else                     mode = MD_READ;
        end
    end
endmodule

// File: rtl/eprom_pgm_ctl.sv
// Turns a low pulse on chip enable in program mode into a single write.
// Assumes the write strobe is consumed at the same rising edge it is raised.
module eprom_pgm_ctl
    import eprom_emu_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  mode_t mode,
    input  logic  ce_n,
    output logic  wr_en
);
    logic ce_prev_n;

    // Remember chip enable from the last cycle to find the pulse start
    always_ff @(posedge clk) begin
        if (!rst_n) ce_prev_n <= 1'b1;
        else        ce_prev_n <= ce_n;
    end

    // Write only on the first cycle of the low pulse
    always_comb wr_en = rst_n && (mode == MD_PROGRAM) && ce_prev_n;

    // R6
    one_write_per_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);
endmodule

// File: rtl/eprom_cell_array.sv
// Register storage that can only clear bits on write; erase sets all ones.
// Assumes DEPTH = 2**AW and one write port sharing the read address.
module eprom_cell_array #(
    parameter int AW = 6,
    parameter int W  = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          erase,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] cells [DEPTH];
    logic         wr_go;

    // Erase and reset take priority over a program write
    always_comb wr_go = wr_en && !erase;

    // Update every word: fill with ones or AND in the programmed data
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n || erase)
                cells[i] <= '1;
            else if (wr_go && (addr == AW'(i)))
                cells[i] <= cells[i] & wdata;
        end
    end

    // Asynchronous read of the addressed word
    always_comb rdata = cells[addr];

    // R6
    clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go && $past(rst_n)) |=> ((cells[$past(addr)] & ~$past(cells[addr])) == '0));
    // R1
    erase_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase |=> (rdata == '1));
endmodule

// File: rtl/eprom_out_mux.sv
// Steers the stored word or identifier code onto the lanes for each mode.
// Assumes lane 15 is never driven in byte mode, since it is then an input.
module eprom_out_mux
    import eprom_emu_pkg::*;
(
    input  mode_t             mode,
    input  logic              byte_n,
    input  logic              byte_hi,
    input  logic              id_lsb,
    input  logic [WORD_W-1:0] rdata,
    output logic [WORD_W-1:0] dq_out,
    output logic [WORD_W-1:0] dq_oe
);
    logic [WORD_W-1:0] src_word;
    logic [WORD_W-1:0] lane_val;
    logic [WORD_W-1:0] lane_en;
    logic              drive;

    // Pick the identifier code or the array word
    always_comb begin
        if (mode == MD_IDENT)
            src_word = {{HALF_W{1'b0}}, (id_lsb ? DEV_CODE : MFR_CODE)};
        else
            src_word = rdata;
    end

    // Output is active in read, identifier and verify modes
    always_comb drive = (mode == MD_READ) || (mode == MD_IDENT) || (mode == MD_VERIFY);

    // Per-lane value and enable, upper lanes idle in byte mode
    for (genvar l = 0; l < WORD_W; l++) begin : g_lane
        if (l < HALF_W) begin : g_low
            always_comb begin
                lane_val[l] = byte_n ? src_word[l] :
                              (byte_hi ? src_word[l + HALF_W] : src_word[l]);
                lane_en[l]  = drive;
            end
        end else begin : g_high
            always_comb begin
                lane_val[l] = src_word[l];
                lane_en[l]  = drive && byte_n;
            end
        end
    end

    // Gate disabled lanes to zero
    always_comb begin
        dq_oe  = lane_en;
        dq_out = lane_val & lane_en;
    end
endmodule

// File: rtl/eprom_emu.sv
// Top of the EPROM emulator: mode decode, program pulse control,
// storage and lane steering. Assumes AW >= 2 so the identifier check
// has address bits above bit 0.
module eprom_emu
    import eprom_emu_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              erase,
    input  logic [AW-1:0]     addr,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              byte_n,
    input  logic              vpp_hi,
    input  logic              a9_hv,
    input  logic [WORD_W-1:0] dq_in,
    output logic [WORD_W-1:0] dq_out,
    output logic [WORD_W-1:0] dq_oe
);
    mode_t             mode;
    logic              id_sel;
    logic              wr_en;
    logic [WORD_W-1:0] rdata;
    logic              byte_hi;

    // Identifier readout needs the high voltage and all other lines low
    always_comb id_sel = a9_hv && (addr[AW-1:1] == '0);

    // Shared pin acts as byte address only in byte-wide organisation
    always_comb byte_hi = !byte_n && dq_in[WORD_W-1];

    eprom_mode_dec u_dec (
        .ce_n   (ce_n),
        .oe_n   (oe_n),
        .vpp_hi (vpp_hi),
        .id_sel (id_sel),
        .mode   (mode)
    );

    eprom_pgm_ctl u_pgm (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (mode),
        .ce_n  (ce_n),
        .wr_en (wr_en)
    );

    eprom_cell_array #(.AW(AW), .W(WORD_W)) u_arr (
        .clk   (clk),
        .rst_n (rst_n),
        .erase (erase),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (dq_in),
        .rdata (rdata)
    );

    eprom_out_mux u_mux (
        .mode    (mode),
        .byte_n  (byte_n),
        .byte_hi (byte_hi),
        .id_lsb  (addr[0]),
        .rdata   (rdata),
        .dq_out  (dq_out),
        .dq_oe   (dq_oe)
    );

    // R5
    standby_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n && !vpp_hi) |-> (dq_oe == '0));
    // R4
    out_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && oe_n && !vpp_hi) |-> (dq_oe == '0));
    // R3
    byte_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && !byte_n) |-> (dq_oe == 16'h00FF));
    // R9
    ident_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!vpp_hi && a9_hv && (addr[AW-1:1] == '0) && !ce_n && !oe_n && byte_n)
        |-> (dq_out == (addr[0] ? 16'h00B2 : 16'h0020)));
    // R11
    idle_lane_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((dq_out & ~dq_oe) == '0));
endmodule

// File: tb/sim_eprom_emu.sv
// Bench for eprom_emu: behavioural reference compared every cycle plus
// directed checks tagged by requirement.
module sim_eprom_emu;
    localparam int AW = 6;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          erase = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          ce_n = 1'b1;
    logic          oe_n = 1'b1;
    logic          byte_n = 1'b1;
    logic          vpp_hi = 1'b0;
    logic          a9_hv = 1'b0;
    logic [15:0]   dq_in = '0;
    logic [15:0]   dq_out;
    logic [15:0]   dq_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    eprom_emu #(.AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .erase(erase), .addr(addr),
        .ce_n(ce_n), .oe_n(oe_n), .byte_n(byte_n), .vpp_hi(vpp_hi),
        .a9_hv(a9_hv), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    // Reference contents and pulse memory
    logic [15:0] ref_mem [DEPTH];
    bit          ref_ce_prev = 1'b1;

    always @(posedge clk) begin
        if (!rst_n || erase) begin
            foreach (ref_mem[i]) ref_mem[i] = 16'hFFFF;
        end else if (vpp_hi && oe_n && !ce_n && ref_ce_prev) begin
            ref_mem[addr] = ref_mem[addr] & dq_in;
        end
        ref_ce_prev = rst_n ? ce_n : 1'b1;
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Expected outputs from pins and reference contents
    always @(negedge clk) begin
        #5;
        if (rst_n && !done) begin
            logic [15:0] word, e_out, e_oe;
            bit ident, rd;
            string tag;
            ident = !vpp_hi && a9_hv && ((addr >> 1) == 0);
            rd = 1'b0;
            tag = "R5";
            if (vpp_hi) begin
                if (!ce_n && oe_n)      tag = "R6";
                else if (ce_n && oe_n)  tag = "R8";
                else begin rd = 1'b1; tag = ce_n ? "R7" : "R2"; end
            end else if (ce_n)          tag = "R5";
            else if (oe_n)              tag = "R4";
            else begin rd = 1'b1; tag = ident ? "R9" : "R2"; end
            word = ident ? (addr[0] ? 16'h00B2 : 16'h0020) : ref_mem[addr];
            e_out = 16'h0; e_oe = 16'h0;
            if (rd) begin
                if (byte_n) begin e_out = word; e_oe = 16'hFFFF; end
                else begin
                    e_out = {8'h00, (dq_in[15] ? word[15:8] : word[7:0])};
                    e_oe = 16'h00FF;
                    tag = "R3";
                end
            end
            chk({tag, " dq_oe per cycle"}, dq_oe, e_oe);
            chk({tag, " dq_out per cycle (R11)"}, dq_out, e_out);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pins(input logic c, input logic o, input logic v, input logic [AW-1:0] a,
                        input logic [15:0] d);
        ce_n = c; oe_n = o; vpp_hi = v; addr = a; dq_in = d;
    endtask

    // Directed check just after the inputs settle
    task automatic look(input string req, input logic [15:0] e_out, input logic [15:0] e_oe);
        #3;
        chk({req, " dq_out"}, dq_out, e_out);
        chk({req, " dq_oe"}, dq_oe, e_oe);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        // R1 reset state
        pins(0, 0, 0, 6'd5, 16'h0); look("R1", 16'hFFFF, 16'hFFFF); tick(1);
        // R6 program 0x1234 into word 5
        pins(1, 1, 1, 6'd5, 16'h1234); tick(1);
        ce_n = 1'b0; look("R6", 16'h0, 16'h0); tick(1);
        ce_n = 1'b1; tick(1);
        // R7 verify
        oe_n = 1'b0; look("R7", 16'h1234, 16'hFFFF); tick(1);
        // R6 long pulse, data changed mid-pulse must not apply
        pins(1, 1, 1, 6'd5, 16'hFF0F); tick(1);
        ce_n = 1'b0; tick(1);
        dq_in = 16'h0000; tick(2);
        ce_n = 1'b1; tick(1);
        oe_n = 1'b0; look("R6 and-only single write", 16'h1204, 16'hFFFF); tick(1);
        // R8 inhibit with zero data on the bus
        pins(1, 1, 1, 6'd5, 16'h0000); look("R8", 16'h0, 16'h0); tick(3);
        oe_n = 1'b0; look("R8 no change", 16'h1204, 16'hFFFF); tick(1);
        // R2 word reads
        pins(0, 0, 0, 6'd5, 16'h0); look("R2", 16'h1204, 16'hFFFF); tick(1);
        addr = 6'd6; look("R2 erased word", 16'hFFFF, 16'hFFFF); tick(1);
        pins(0, 0, 1, 6'd5, 16'h0); look("R2 with vpp", 16'h1204, 16'hFFFF); tick(1);
        // R3 byte reads
        vpp_hi = 1'b0; byte_n = 1'b0;
        dq_in = 16'h0000; look("R3 low byte", 16'h0004, 16'h00FF); tick(1);
        dq_in = 16'h8000; look("R3 high byte", 16'h0012, 16'h00FF); tick(1);
        byte_n = 1'b1;
        // R4 and R5
        pins(0, 1, 0, 6'd5, 16'h0); look("R4", 16'h0, 16'h0); tick(1);
        pins(1, 0, 0, 6'd5, 16'h0); look("R5 oe low", 16'h0, 16'h0); tick(1);
        pins(1, 1, 0, 6'd5, 16'h0); look("R5 oe high", 16'h0, 16'h0); tick(1);
        // R9 identifier
        a9_hv = 1'b1;
        pins(0, 0, 0, 6'd0, 16'h0); look("R9 maker", 16'h0020, 16'hFFFF); tick(1);
        addr = 6'd1; look("R9 device", 16'h00B2, 16'hFFFF); tick(1);
        byte_n = 1'b0; look("R9 byte mode", 16'h00B2, 16'h00FF); tick(1);
        byte_n = 1'b1;
        // R10 other address lines set
        addr = 6'd5; look("R10", 16'h1204, 16'hFFFF); tick(1);
        a9_hv = 1'b0;
        // R1 erase after programming word 7 to zero
        pins(1, 1, 1, 6'd7, 16'h0000); tick(1);
        ce_n = 1'b0; tick(1);
        pins(0, 0, 0, 6'd7, 16'h0); look("R6 word 7", 16'h0000, 16'hFFFF); tick(1);
        erase = 1'b1; tick(1);
        erase = 1'b0; look("R1 erase word 7", 16'hFFFF, 16'hFFFF); tick(1);
        addr = 6'd5; look("R1 erase word 5", 16'hFFFF, 16'hFFFF); tick(1);
        // R1 erase beats a simultaneous program pulse
        pins(1, 1, 1, 6'd9, 16'h0000); tick(1);
        ce_n = 1'b0; erase = 1'b1; tick(1);
        erase = 1'b0; ce_n = 1'b1; tick(1);
        pins(0, 0, 0, 6'd9, 16'h0); look("R1 erase priority", 16'hFFFF, 16'hFFFF); tick(1);
        // Sweep of mixed writes checked by the reference each cycle
        for (int k = 0; k < 40; k++) begin
            pins(1, 1, 1, AW'(k % 8), 16'(16'hFFFF ^ (16'h1 << (k % 16)))); tick(1);
            ce_n = 1'b0; tick(1 + (k % 3));
            ce_n = 1'b1; oe_n = 1'b0; tick(1);
            byte_n = k[0]; pins(0, 0, 0, AW'(k % 8), {k[1], 15'h0}); tick(1);
            byte_n = 1'b1;
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule